// File: doc/BRIEF.md
# Program-Memory Region Lock Checker

This block keeps two 2-bit protection fields, one for the main application region of program memory and one for the application table region above it. Each field independently decides whether self-programming writes into its region are refused, whether program-memory reads into its region are refused, or both. Every access presented on the access port gets a same-cycle grant or deny answer, computed from the registered fields.

The fields can only be made stricter by software. A lock write is merged as a bitwise AND into the current value, so a cleared bit stays cleared until a chip-erase pulse returns both fields to the unrestricted code. Read protection only applies to reads issued by code executing from the boot region; reads issued from anywhere else pass this check. When read protection is active and the interrupt vectors live in the boot region, an interrupt-suppress output is raised while execution is in the application region.

Region boundaries are parameters. Addresses below the application region or at or above the end of the table region belong to neither region and are always granted.

Top module: `flash_lock_unit`

## Requirements
- R1: After reset both lock fields read 2'b11 (no restriction) on `app_lock_o` and `tbl_lock_o`.
- R2: A pulse on `lock_wr_i` sets each field to the AND of its current value and the requested value (`lock_wdata_i[1:0]` for the application field, `lock_wdata_i[3:2]` for the table field); the new value is visible after the next rising clock edge, and a request that would set a cleared bit back to 1 leaves that bit at 0.
- R3: A pulse on `erase_i` sets both fields to 2'b11 at the next rising edge, and wins over a lock write in the same cycle.
- R4: A read (`acc_write_i`=0) into a region whose field has bit 1 cleared (codes 01, 00) is denied only when `from_boot_i`=1; with `from_boot_i`=0 it is granted.
- R5: A self-programming write (`acc_write_i`=1) into a region whose field has bit 0 cleared (codes 10, 00) is denied, regardless of `from_boot_i`.
- R6: Addresses in [APP_LO, TBL_LO) are checked against the application field only, and addresses in [TBL_LO, TBL_HI) against the table field only.
- R7: Addresses below APP_LO or at or above TBL_HI are always granted; with `acc_valid_i`=1 exactly one of `grant_o`/`deny_o` is high, with `acc_valid_i`=0 both are low.
- R8: `irq_suppress_o` is high exactly when `ivec_in_boot_i`=1, `exec_in_app_i`=1 and at least one field has bit 1 cleared.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_wr_i | input | 1 | Lock-field write strobe |
| lock_wdata_i | input | 4 | Requested fields: [3:2] table, [1:0] application |
| erase_i | input | 1 | Chip-erase pulse, unlocks both fields |
| acc_valid_i | input | 1 | Access to check is present |
| acc_write_i | input | 1 | 1 = self-programming write, 0 = read |
| acc_addr_i | input | ADDR_W | Target program-memory address |
| from_boot_i | input | 1 | Issuing code executes from the boot region |
| ivec_in_boot_i | input | 1 | Interrupt vectors placed in the boot region |
| exec_in_app_i | input | 1 | Execution currently in the application region |
| grant_o | output | 1 | Access allowed |
| deny_o | output | 1 | Access refused |
| irq_suppress_o | output | 1 | Interrupts must be held off |
| app_lock_o | output | 2 | Current application field |
| tbl_lock_o | output | 2 | Current table field |

## Verification
Grant, deny and interrupt-suppress are combinational, so they are due in the same cycle as the access inputs; the bench drives on the falling edge and samples one nanosecond later, before any rising edge. Lock-field changes from a write or erase pulse are due one rising edge after the strobe, so the bench holds the strobe across one rising edge, removes it at the following falling edge and reads the fields there. The sweep covers all sixteen field pairs against boundary addresses, both access types and both issuing regions.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  typedef logic [1:0] lock_t;
  localparam lock_t LOCK_NONE = 2'b11;

  typedef enum logic [1:0] {REG_NONE = 2'd0, REG_APP = 2'd1, REG_TBL = 2'd2} region_e;

  function automatic logic wr_blocked(lock_t l);
    return ~l[0];
  endfunction

  function automatic logic rd_blocked(lock_t l);
    return ~l[1];
  endfunction
endpackage

// File: rtl/flash_lock_field.sv
module flash_lock_field
  import flash_lock_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  lock_t wdata_i,
  input  logic  erase_i,
  output lock_t q_o
);
  lock_t q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= LOCK_NONE;
    else if (erase_i) q <= LOCK_NONE;
    else if (wr_i)    q <= q & wdata_i;  // tighten only
  end
  assign q_o = q;
endmodule

// File: rtl/flash_region_decode.sv
module flash_region_decode
  import flash_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] APP_LO = 12'h040,
  parameter logic [ADDR_W-1:0] TBL_LO = 12'hA00,
  parameter logic [ADDR_W-1:0] TBL_HI = 12'hC00
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  always_comb begin
    if (addr_i >= TBL_LO && addr_i < TBL_HI)      region_o = REG_TBL;
    else if (addr_i >= APP_LO && addr_i < TBL_LO) region_o = REG_APP;
    else                                          region_o = REG_NONE;
  end
endmodule

// File: rtl/flash_access_check.sv
module flash_access_check
  import flash_lock_pkg::*;
(
  input  logic    valid_i,
  input  logic    write_i,
  input  logic    from_boot_i,
  input  region_e region_i,
  input  lock_t   app_lock_i,
  input  lock_t   tbl_lock_i,
  output logic    grant_o,
  output logic    deny_o
);
  lock_t sel;
  logic  refuse;
  always_comb begin
    unique case (region_i)
      REG_APP: sel = app_lock_i;
      REG_TBL: sel = tbl_lock_i;
      default: sel = LOCK_NONE;
    endcase
    refuse = write_i ? wr_blocked(sel) : (from_boot_i & rd_blocked(sel));
  end
  assign grant_o = valid_i & ~refuse;
  assign deny_o  = valid_i &  refuse;
endmodule

// File: rtl/flash_lock_unit.sv
module flash_lock_unit
  import flash_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] APP_LO = 12'h040,
  parameter logic [ADDR_W-1:0] TBL_LO = 12'hA00,
  parameter logic [ADDR_W-1:0] TBL_HI = 12'hC00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_wr_i,
  input  logic [3:0]        lock_wdata_i,
  input  logic              erase_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              from_boot_i,
  input  logic              ivec_in_boot_i,
  input  logic              exec_in_app_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic              irq_suppress_o,
  output logic [1:0]        app_lock_o,
  output logic [1:0]        tbl_lock_o
);
  localparam int unsigned NFIELD = 2;

  lock_t   field_q [NFIELD];
  region_e region;

  // field 0: application, field 1: table
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    flash_lock_field i_field (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (lock_wr_i),
      .wdata_i (lock_wdata_i[2*g +: 2]),
      .erase_i (erase_i),
      .q_o     (field_q[g])
    );
  end

  flash_region_decode #(
    .ADDR_W (ADDR_W), .APP_LO (APP_LO), .TBL_LO (TBL_LO), .TBL_HI (TBL_HI)
  ) i_decode (
    .addr_i   (acc_addr_i),
    .region_o (region)
  );

  flash_access_check i_check (
    .valid_i     (acc_valid_i),
    .write_i     (acc_write_i),
    .from_boot_i (from_boot_i),
    .region_i    (region),
    .app_lock_i  (field_q[0]),
    .tbl_lock_i  (field_q[1]),
    .grant_o     (grant_o),
    .deny_o      (deny_o)
  );

  assign irq_suppress_o = ivec_in_boot_i & exec_in_app_i &
                          (rd_blocked(field_q[0]) | rd_blocked(field_q[1]));
  assign app_lock_o = field_q[0];
  assign tbl_lock_o = field_q[1];
endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] APP_LO = 12'h040,
  parameter logic [ADDR_W-1:0] TBL_HI = 12'hC00
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              erase_i,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              from_boot_i,
  input logic              ivec_in_boot_i,
  input logic              exec_in_app_i,
  input logic              grant_o,
  input logic              deny_o,
  input logic              irq_suppress_o,
  input logic [1:0]        app_lock_o,
  input logic [1:0]        tbl_lock_o
);
  a_r2_no_loosen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_i |=> ((app_lock_o & ~$past(app_lock_o)) == 2'b00) &&
                 ((tbl_lock_o & ~$past(tbl_lock_o)) == 2'b00));

  a_r3_erase_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (app_lock_o == 2'b11) && (tbl_lock_o == 2'b11));

  a_r4_read_elsewhere: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && !from_boot_i) |-> grant_o);

  a_r7_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i ? $onehot({grant_o, deny_o}) : !(grant_o || deny_o));

  a_r7_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && (acc_addr_i < APP_LO || acc_addr_i >= TBL_HI)) |-> grant_o);

  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_suppress_o |-> (ivec_in_boot_i && exec_in_app_i &&
                        !(app_lock_o[1] && tbl_lock_o[1])));
endmodule

bind flash_lock_unit flash_lock_chk #(
  .ADDR_W (ADDR_W), .APP_LO (APP_LO), .TBL_HI (TBL_HI)
) i_flash_lock_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .erase_i        (erase_i),
  .acc_valid_i    (acc_valid_i),
  .acc_write_i    (acc_write_i),
  .acc_addr_i     (acc_addr_i),
  .from_boot_i    (from_boot_i),
  .ivec_in_boot_i (ivec_in_boot_i),
  .exec_in_app_i  (exec_in_app_i),
  .grant_o        (grant_o),
  .deny_o         (deny_o),
  .irq_suppress_o (irq_suppress_o),
  .app_lock_o     (app_lock_o),
  .tbl_lock_o     (tbl_lock_o)
);

// File: tb/test_flash_lock_unit.sv
`timescale 1ns/1ps
module test_flash_lock_unit;
  localparam int ADDR_W = 12;
  localparam logic [11:0] APP_LO = 12'h040;
  localparam logic [11:0] TBL_LO = 12'hA00;
  localparam logic [11:0] TBL_HI = 12'hC00;

  logic clk = 0, rst_ni = 0;
  logic lock_wr = 0, erase = 0, valid = 0, wr = 0, boot = 0, ivec = 0, inapp = 0;
  logic [3:0] wdata = 0;
  logic [11:0] addr = 0;
  logic grant, deny, irqs;
  logic [1:0] app_l, tbl_l;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_lock_unit #(.ADDR_W(ADDR_W), .APP_LO(APP_LO), .TBL_LO(TBL_LO), .TBL_HI(TBL_HI))
  i_flash_lock_unit (
    .clk_i(clk), .rst_ni(rst_ni), .lock_wr_i(lock_wr), .lock_wdata_i(wdata),
    .erase_i(erase), .acc_valid_i(valid), .acc_write_i(wr), .acc_addr_i(addr),
    .from_boot_i(boot), .ivec_in_boot_i(ivec), .exec_in_app_i(inapp),
    .grant_o(grant), .deny_o(deny), .irq_suppress_o(irqs),
    .app_lock_o(app_l), .tbl_lock_o(tbl_l));

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one strobe cycle: drive at negedge, held over a posedge, cleared at next negedge
  task automatic pulse(logic w, logic e, logic [3:0] d);
    lock_wr = w; erase = e; wdata = d;
    @(negedge clk);
    lock_wr = 0; erase = 0;
  endtask

  function automatic logic model_deny(logic [1:0] a, logic [1:0] t, logic [11:0] ad,
                                      logic w, logic b);
    logic [1:0] s;
    if (ad >= TBL_LO && ad < TBL_HI)      s = t;
    else if (ad >= APP_LO && ad < TBL_LO) s = a;
    else                                  s = 2'b11;
    return w ? ~s[0] : (b & ~s[1]);
  endfunction

  logic [11:0] pts [8] = '{12'h000, 12'h03F, 12'h040, 12'h500, 12'h9FF,
                           12'hA00, 12'hBFF, 12'hC00};

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 app reset", {2'b0, app_l}, 4'h3);
    chk("R1 tbl reset", {2'b0, tbl_l}, 4'h3);
    chk("R7 idle", {2'b0, grant, deny}, 4'h0);
    rst_ni = 1;
    @(negedge clk);

    // R2: AND merge, no loosening
    pulse(1, 0, 4'b1110);
    chk("R2 app tighten", {2'b0, app_l}, 4'h2);
    chk("R2 tbl kept", {2'b0, tbl_l}, 4'h3);
    pulse(1, 0, 4'b0101);
    chk("R2 app and", {2'b0, app_l}, 4'h0);
    chk("R2 tbl and", {2'b0, tbl_l}, 4'h1);
    pulse(1, 0, 4'b1111);
    chk("R2 no loosen", {tbl_l, app_l}, 4'h4);
    // R3: erase wins over write
    pulse(1, 1, 4'b0000);
    chk("R3 erase priority", {tbl_l, app_l}, 4'hF);

    // Sweep all field pairs
    for (int f = 0; f < 16; f++) begin
      pulse(0, 1, 4'h0);
      pulse(1, 0, f[3:0]);
      chk("R2 set", {tbl_l, app_l}, f[3:0]);
      for (int p = 0; p < 8; p++)
        for (int m = 0; m < 4; m++) begin
          logic ed;
          valid = 1; addr = pts[p]; wr = m[0]; boot = m[1];
          #1;
          ed = model_deny(f[1:0], f[3:2], pts[p], m[0], m[1]);
          if (m[0])      chk("R5 write", {2'b0, grant, deny}, {2'b0, ~ed, ed});
          else if (m[1]) chk("R4 boot read", {2'b0, grant, deny}, {2'b0, ~ed, ed});
          else           chk("R4 other read", {2'b0, grant, deny}, 4'h2);
          if (pts[p] < APP_LO || pts[p] >= TBL_HI)
            chk("R7 outside", {2'b0, grant, deny}, 4'h2);
          else
            chk("R6 region field", {2'b0, grant, deny}, {2'b0, ~ed, ed});
          @(negedge clk);
        end
      valid = 0;
      #1;
      chk("R7 no valid", {2'b0, grant, deny}, 4'h0);
      for (int k = 0; k < 4; k++) begin
        logic ei;
        ivec = k[0]; inapp = k[1];
        #1;
        ei = k[0] & k[1] & (~f[1] | ~f[3]);
        chk("R8 irq", {3'b0, irqs}, {3'b0, ei});
      end
      ivec = 0; inapp = 0;
      @(negedge clk);
    end

    pulse(0, 1, 4'h0);
    chk("R3 erase", {tbl_l, app_l}, 4'hF);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #800000;
    join_any
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule